// File: doc/BRIEF.md
# Prescaled Timer with Toggle Output Modulator

This block is an up-counter timer whose count advances once per prescaler period. A single control byte written over a simple write port sets the run request, the event masks and the output preset. Two bus-writable compare values can each clear the counter when it matches, and each has its own mask. A toggle flip-flop drives the modulator output. It inverts on a compare-A match, on counter overflow, or when the timer starts, and each of these sources has its own enable.

The run request passes through a chain of synchronizer flops before it reaches the counting logic, as it would when crossing into a separate timer clock domain. Bit 7 of the control readback shows the synchronized run state and not the value that was written. A self-clearing bit clears the prescaler and the counter. The output preset loads the flip-flop directly. Both of these actions are accepted only while the synchronized run state is low.

Top module: `timer_toggle_mod`

## Requirements
- R1: After reset the control readback (address 0) is 0x00, both compare readbacks (addresses 1 and 2) are 0xFF, `count` is 0, and `mod_out` and `ovf_pulse` are 0.
- R2: Bit 7 of the control readback follows bit 7 of the written control byte exactly SYNC_STAGES clock cycles after the write edge, on both enabling and disabling.
- R3: While running, `count` advances by one every 2^PRE_LOG2 cycles and wraps from 0xFF to 0x00. While stopped, the prescaler and `count` hold.
- R4: Writing the control byte with bit 5 set clears the prescaler and `count` when the timer is stopped. The same write has no effect on them while the timer is running.
- R5: Bit 5 of the control readback reads 1 for exactly one cycle after a write that set it, and then reads 0.
- R6: A control write while stopped loads `mod_out` from bit 4 (1 sets, 0 clears). While running, bit 4 does not affect `mod_out`.
- R7: With control bit 3 set, a count step that finds `count` equal to compare A (address 1) loads 0 instead of incrementing.
- R8: With control bit 2 set, a count step that finds `count` equal to compare B (address 2) loads 0 instead of incrementing.
- R9: With control bit 1 set, a count step that finds `count` equal to compare A inverts `mod_out`.
- R10: With control bit 0 set, a count step from 0xFF to 0x00 inverts `mod_out` and raises `ovf_pulse` for exactly one cycle.
- R11: With control bit 6 set, `mod_out` inverts once on the cycle the synchronized run state rises. With bit 6 clear, starting leaves `mod_out` unchanged.
- R12: When several toggle events fall on the same cycle, `mod_out` inverts only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 compare A, 2 compare B |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as write |
| rd_data | output | 8 | Read data (combinational) |
| count | output | 8 | Current counter value |
| mod_out | output | 1 | Toggle flip-flop output |
| ovf_pulse | output | 1 | One-cycle counter output clock on overflow |

## Verification
The bench sets up a compare value of 0xFF with both the compare toggle and the overflow toggle enabled. A design that inverts once per event would then flip the output twice and leave it unchanged. The bench writes the clear and preset bits while the timer runs, where a design that failed to gate them would clear the count or move the output. It counts the cycles between the enable write and the readback change in both directions, so a missing or extra synchronizer stage shows up. It also runs compare-clear with each mask alone, which exposes a design that crosses the masks or clears on the wrong compare.

// File: rtl/timer_toggle_mod.sv
module timer_toggle_mod #(
  parameter int CW          = 8,
  parameter int PRE_LOG2    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [1:0]    rd_addr,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count,
  output logic          mod_out,
  output logic          ovf_pulse
);

  localparam int SL = SYNC_STAGES - 1;

  logic en_q, tos_q, res_q, top_q, ma_q, mb_q, ctm_q, otm_q;
  logic [CW-1:0] cmp_a, cmp_b, cnt;
  logic [PRE_LOG2-1:0] pre;
  logic [SYNC_STAGES-1:0] sync;
  logic run_d, tff, ovf_q;

  wire ctrl_wr = wr_en && (wr_addr == 2'd0);
  wire run     = sync[SL];
  wire tick    = run && (&pre);
  wire hit_a   = (cnt == cmp_a);
  wire hit_b   = (cnt == cmp_b);
  wire clr     = tick && ((hit_a && ma_q) || (hit_b && mb_q));
  wire ovf     = tick && (&cnt) && !clr;
  wire flip    = (run && !run_d && tos_q) | (tick && hit_a && ctm_q) | (ovf && otm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, tos_q, res_q, top_q, ma_q, mb_q, ctm_q, otm_q} <= '0;
      cmp_a <= '1;
      cmp_b <= '1;
    end else begin
      res_q <= 1'b0;
      if (ctrl_wr) {en_q, tos_q, res_q, top_q, ma_q, mb_q, ctm_q, otm_q} <= wr_data;
      if (wr_en && wr_addr == 2'd1) cmp_a <= wr_data[CW-1:0];
      if (wr_en && wr_addr == 2'd2) cmp_b <= wr_data[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= '0;
      run_d <= 1'b0;
    end else begin
      sync[0] <= en_q;
      for (int i = 1; i < SYNC_STAGES; i++) sync[i] <= sync[i-1];
      run_d <= run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (ctrl_wr && wr_data[5] && !run) begin
      pre <= '0;
      cnt <= '0;
    end else if (run) begin
      pre <= pre + 1'b1;
      if (tick) cnt <= clr ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tff   <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf && otm_q;
      if (ctrl_wr && !run) tff <= wr_data[4];
      else if (flip)       tff <= ~tff;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {run, tos_q, res_q, top_q, ma_q, mb_q, ctm_q, otm_q};
      2'd1:    rd_data = 8'(cmp_a);
      2'd2:    rd_data = 8'(cmp_b);
      default: rd_data = 8'h00;
    endcase
  end

  assign count     = cnt;
  assign mod_out   = tff;
  assign ovf_pulse = ovf_q;

  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(ctrl_wr && wr_data[5])) |=> (count == $past(count)));

  assert_res_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0 && rd_data[5] && !ctrl_wr) |=> !res_q);

  assert_preset_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_d && !tick) |=> $stable(mod_out));

  assert_clear_on_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit_a && ma_q && !ctrl_wr) |=> (count == '0));

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  assert_start_flip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run) && tos_q && !tick) |=> (mod_out != $past(mod_out)));

endmodule

// File: tb/timer_toggle_mod_tb.sv
`timescale 1ns/1ps
module timer_toggle_mod_tb_top;
  localparam int PRE_LOG2 = 2;
  localparam int SYNC     = 2;
  localparam int PDIV     = 1 << PRE_LOG2;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data, count;
  logic mod_out, ovf_pulse;

  timer_toggle_mod #(.CW(8), .PRE_LOG2(PRE_LOG2), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .count(count), .mod_out(mod_out),
    .ovf_pulse(ovf_pulse));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  string phase = "R1 reset";

  // behavioural reference
  int m_ctrl, m_ca, m_cb, m_cnt, m_pre, m_tff, m_ovf, m_rund;
  int m_sync[SYNC];

  function automatic int m_run();
    return m_sync[SYNC-1];
  endfunction

  function automatic int exp_rd(int a);
    if (a == 0) return (m_run() << 7) | (m_ctrl & 8'h7F);
    if (a == 1) return m_ca;
    if (a == 2) return m_cb;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_ca = 255; m_cb = 255; m_cnt = 0; m_pre = 0; m_tff = 0; m_ovf = 0; m_rund = 0;
      for (int i = 0; i < SYNC; i++) m_sync[i] = 0;
    end else begin
      int run, tick, ha, hb, clr, ovf, flip;
      run  = m_run();
      tick = run && (m_pre == PDIV - 1);
      ha   = (m_cnt == m_ca);
      hb   = (m_cnt == m_cb);
      clr  = tick && ((ha && m_ctrl[3]) || (hb && m_ctrl[2]));
      ovf  = tick && (m_cnt == 255) && !clr;
      flip = (run && !m_rund && m_ctrl[6]) || (tick && ha && m_ctrl[1]) || (ovf && m_ctrl[0]);
      m_ovf = ovf && m_ctrl[0];
      if (run) begin
        m_pre = (m_pre + 1) % PDIV;
        if (tick) m_cnt = clr ? 0 : (m_cnt + 1) % 256;
      end
      if (wr_en && wr_addr == 0 && !run) m_tff = wr_data[4];
      else if (flip) m_tff = 1 - m_tff;
      if (wr_en && wr_addr == 0 && wr_data[5] && !run) begin m_pre = 0; m_cnt = 0; end
      for (int i = SYNC - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
      m_sync[0] = m_ctrl[7];
      m_rund = run;
      m_ctrl = m_ctrl & ~32'h20;
      if (wr_en && wr_addr == 0) m_ctrl = wr_data;
      if (wr_en && wr_addr == 1) m_ca = wr_data;
      if (wr_en && wr_addr == 2) m_cb = wr_data;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk({phase, " count"}, count, m_cnt);
      chk({phase, " mod_out"}, mod_out, m_tff);
      chk({phase, " ovf_pulse"}, ovf_pulse, m_ovf);
      chk({phase, " rd_data"}, rd_data, exp_rd(rd_addr));
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hold;
    idle(3); rst_n = 1; idle(1); #2;
    chk("R1 ctrl", rd_data, 8'h00);
    chk("R1 count", count, 0);
    chk("R1 mod", mod_out, 0);
    rd_addr = 1; #1 chk("R1 cmpA", rd_data, 8'hFF);
    rd_addr = 2; #1 chk("R1 cmpB", rd_data, 8'hFF);
    rd_addr = 0; idle(1);

    phase = "R2 enable lag";
    wr(0, 8'h80); #2 chk("R2 lag0", rd_data[7], 0);
    idle(1); #2 chk("R2 lag1", rd_data[7], 0);
    idle(1); #2 chk("R2 lag2", rd_data[7], 1);
    phase = "R3 counting"; idle(40);
    chk("R3 advanced", (count >= 9 && count <= 11), 1);
    phase = "R2 disable lag";
    wr(0, 8'h00); #2 chk("R2 off0", rd_data[7], 1);
    idle(1); #2 chk("R2 off1", rd_data[7], 1);
    idle(1); #2 chk("R2 off2", rd_data[7], 0);
    phase = "R3 hold"; hold = count; idle(12);
    chk("R3 hold", count, hold);

    phase = "R4 clear stopped";
    wr(0, 8'h20); #2 chk("R5 res high", rd_data[5], 1);
    chk("R4 cleared", count, 0);
    idle(1); #2 chk("R5 res low", rd_data[5], 0);
    phase = "R4 clear ignored"; wr(0, 8'h80); idle(30);
    wr(0, 8'hA0); #2 chk("R4 not cleared", count != 0, 1);
    idle(5);

    phase = "R6 preset ignored";
    wr(0, 8'h90); idle(3); #2 chk("R6 ignored", mod_out, 0);
    wr(0, 8'h00); idle(4);
    phase = "R6 preset stopped";
    wr(0, 8'h10); #2 chk("R6 set", mod_out, 1);
    wr(0, 8'h00); #2 chk("R6 clear", mod_out, 0);

    phase = "R7 clear on A";
    wr(0, 8'h20); wr(1, 5); wr(0, 8'h88); idle(80);
    wr(0, 8'h00); idle(4);
    phase = "R8 clear on B";
    wr(0, 8'h20); wr(2, 3); wr(0, 8'h84); idle(60);
    wr(0, 8'h00); idle(4);

    phase = "R9 compare toggle";
    wr(0, 8'h20); wr(1, 7); wr(0, 8'h82); idle(1100);
    wr(0, 8'h00); idle(4);

    phase = "R10 overflow";
    wr(0, 8'h20); wr(0, 8'h81); idle(2100);
    wr(0, 8'h00); idle(4);

    phase = "R11 start toggle";
    wr(0, 8'h20); wr(0, 8'h40); wr(0, 8'hC0); idle(3); #2
    chk("R11 flipped", mod_out, 1);
    wr(0, 8'h00); idle(4);
    wr(0, 8'h00); wr(0, 8'h80); idle(3); #2
    chk("R11 no flip", mod_out, 0);
    wr(0, 8'h00); idle(4);

    phase = "R12 merged toggles";
    wr(0, 8'h20); wr(1, 8'hFF); wr(0, 8'h83); idle(1100);
    wr(0, 8'h00); idle(4);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule